// File: doc/BRIEF.md
# LFSR Sample Rate Divider

This block sets the sample rate of a sample playback channel. It divides a step enable by a programmable amount. The count is kept in a 9-bit linear feedback shift register instead of a binary down-counter. A 4-bit rate index picks a nonzero starting pattern from a constant table. The register advances once for each accepted step until it holds the end pattern 9'b100000000. On the next accepted step it loads a fresh starting pattern and raises a one-clock tick.

The step enable is normally driven high on every other system clock. As a result, one output period in system clocks is twice the number of register steps. The rate index is captured with a write strobe. A captured index is used only at the next reload, so a period that is already running always finishes at its old length.

Top module: `lfsr_sample_divider`

## Requirements
- R1: On a clock with `step_en` high, and the register not holding the end pattern, the 9-bit register state s becomes {s[7:0], s[8]^s[4]}. That is, the two taps are bit 9 and bit 5 when bits are counted from 1, and the XOR result enters at the low end.
- R2: The end pattern is 9'b100000000. When a clock with `step_en` high finds the register at the end pattern, `tick` is high for exactly the following clock cycle.
- R3: The step that finds the end pattern loads the starting pattern of the captured rate index, in place of shifting.
- R4: While `step_en` is low the register holds its value, and `tick` stays low.
- R5: A new rate index captured during a period does not change the length of that period. It sets the length of the period that starts at the next reload.
- R6: The active-high synchronous reset clears the captured rate index to 0, loads the starting pattern of index 0, and holds `tick` low.
- R7: Starting patterns, in hex, by index 0 to 15: 1AC, 17D, 0E2, 153, 0B4, 1F1, 09A, 12F, 066, 1C8, 035, 0D9, 14B, 07E, 1E7, 011.
- R8: Let L be the number of R1 steps that take a starting pattern to the end pattern. The distance between ticks is then L+1 accepted steps. With `step_en` high on every other clock, this is 2*(L+1) system clocks.
- R9: `rate_idx` is captured only on a clock with `rate_wr` high. Changes on `rate_idx` without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_idx | input | 4 | Rate index to capture |
| rate_wr | input | 1 | Capture strobe for `rate_idx` |
| step_en | input | 1 | Step enable, normally high on every other clock |
| tick | output | 1 | One-clock pulse at the end of each period |

## Verification
Only the tick interval is visible at the ports. A wrong tap, a wrong shift direction, a wrong table entry or a reload from the wrong index therefore shows up as a changed distance between ticks. The fault becomes visible within one or two periods, which is at most about a thousand clocks. Every index is measured against a pattern-walk count made in the bench from the stated polynomial and seeds. The checks also catch:
- a rate change that cuts a period short;
- a step taken without the enable;
- a captured index taken without the strobe.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;
    localparam int LFSR_W  = 9;
    localparam int TAP_HI  = 9;
    localparam int TAP_LO  = 5;
    localparam int RATE_W  = 4;
    localparam int N_RATES = 1 << RATE_W;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [RATE_W-1:0] rate_t;

    localparam lfsr_t TERM_PAT = lfsr_t'(1) << (LFSR_W - 1);

    localparam lfsr_t SEED_TABLE [N_RATES] = '{
        9'h1AC, 9'h17D, 9'h0E2, 9'h153,
        9'h0B4, 9'h1F1, 9'h09A, 9'h12F,
        9'h066, 9'h1C8, 9'h035, 9'h0D9,
        9'h14B, 9'h07E, 9'h1E7, 9'h011
    };

    typedef struct packed {
        lfsr_t lfsr;
        logic  tick;
    } core_state_t;
endpackage

// File: rtl/lfsr_div_seed_rom.sv
module lfsr_div_seed_rom
    import lfsr_div_pkg::*;
(
    input  rate_t rate_sel,
    output lfsr_t seed_out
);
    always_comb begin
        seed_out = SEED_TABLE[rate_sel];
    end
endmodule

// File: rtl/lfsr_div_rate_reg.sv
module lfsr_div_rate_reg
    import lfsr_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rate_t rate_in,
    input  logic  rate_wr,
    output rate_t rate_q
);
    rate_t rate_d;

    always_comb begin
        rate_d = rate_q;
        if (rate_wr) begin
            rate_d = rate_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
        end else begin
            rate_q <= rate_d;
        end
    end

    // R9: strobe captures the presented index
    p_capture_r9: assert property (@(posedge clk) disable iff (rst)
        rate_wr |=> rate_q == $past(rate_in));
    // R9: no strobe, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rate_wr |=> $stable(rate_q));
endmodule

// File: rtl/lfsr_div_core.sv
module lfsr_div_core
    import lfsr_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_en,
    input  lfsr_t seed_in,
    input  lfsr_t reset_seed,
    output logic  tick_q
);
    core_state_t st_d, st_q;
    lfsr_t       shifted;
    logic        at_term;

    // Shift left by one: each bit takes its lower neighbour.
    genvar gi;
    generate
        for (gi = 1; gi < LFSR_W; gi++) begin : g_shift
            assign shifted[gi] = st_q.lfsr[gi-1];
        end
    endgenerate
    assign shifted[0] = st_q.lfsr[TAP_HI-1] ^ st_q.lfsr[TAP_LO-1];

    assign at_term = (st_q.lfsr == TERM_PAT);

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (step_en) begin
            if (at_term) begin
                st_d.lfsr = seed_in;
                st_d.tick = 1'b1;
            end else begin
                st_d.lfsr = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lfsr <= reset_seed;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_q = st_q.tick;

    // R4: no step, no movement
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(st_q.lfsr));
    // R2: tick is a single clock wide
    p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    // R3: a tick coincides with a freshly loaded seed
    p_reload_seed_r3: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> st_q.lfsr == $past(seed_in));
    // R1: the register never falls into the all-zero lockup state
    p_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
        st_q.lfsr != '0);
endmodule

// File: rtl/lfsr_sample_divider.sv
module lfsr_sample_divider
    import lfsr_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rate_idx,
    input  logic       rate_wr,
    input  logic       step_en,
    output logic       tick
);
    rate_t rate_q;
    lfsr_t seed_sel;
    lfsr_t seed_zero;

    lfsr_div_rate_reg u_rate (
        .clk     (clk),
        .rst     (rst),
        .rate_in (rate_idx),
        .rate_wr (rate_wr),
        .rate_q  (rate_q)
    );

    lfsr_div_seed_rom u_rom (
        .rate_sel (rate_q),
        .seed_out (seed_sel)
    );

    lfsr_div_seed_rom u_rom_rst (
        .rate_sel ('0),
        .seed_out (seed_zero)
    );

    lfsr_div_core u_core (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .seed_in    (seed_sel),
        .reset_seed (seed_zero),
        .tick_q     (tick)
    );

    // R4: tick only follows an accepted step
    p_tick_needs_step_r4: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(step_en));
endmodule

// File: tb/lfsr_sample_divider_test.sv
module lfsr_sample_divider_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // {rate index, seed} per R7
    localparam logic [12:0] VEC [NVEC] = '{
        {4'd0, 9'h1AC}, {4'd1, 9'h17D}, {4'd2, 9'h0E2}, {4'd3, 9'h153},
        {4'd4, 9'h0B4}, {4'd5, 9'h1F1}, {4'd6, 9'h09A}, {4'd7, 9'h12F},
        {4'd8, 9'h066}, {4'd9, 9'h1C8}, {4'd10, 9'h035}, {4'd11, 9'h0D9},
        {4'd12, 9'h14B}, {4'd13, 9'h07E}, {4'd14, 9'h1E7}, {4'd15, 9'h011}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rate_idx = '0;
    logic       rate_wr = 1'b0;
    logic       step_en = 1'b0;
    logic       tick;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    lfsr_sample_divider uut (
        .clk(clk), .rst(rst), .rate_idx(rate_idx),
        .rate_wr(rate_wr), .step_en(step_en), .tick(tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Steps between ticks per R1 and R8: walk to the end pattern, plus the reload step.
    function automatic int period_steps(input logic [8:0] seed);
        logic [8:0] s;
        int n;
        s = seed;
        n = 0;
        while (s != 9'h100 && n < 1000) begin
            s = {s[7:0], s[8] ^ s[4]};
            n++;
        end
        return n + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One half-rate step: enable for one clock, then idle for one clock.
    task automatic do_step(output bit t);
        bit t2;
        step_en = 1'b1;
        @(negedge clk);
        t = tick;
        step_en = 1'b0;
        @(negedge clk);
        t2 = tick;
        if (t) check("R2 single-cycle tick", int'(t2), 0);
    endtask

    task automatic wait_tick(output int n);
        bit t;
        n = 0;
        do begin
            do_step(t);
            n++;
        end while (!t && n < 2000);
    endtask

    task automatic write_rate(input logic [3:0] r);
        rate_idx = r;
        rate_wr = 1'b1;
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            summary();
        end
    end

    initial begin
        int n;
        int m;
        bit t;
        @(negedge clk);
        @(negedge clk);
        check("R6 tick low in reset", int'(tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R6 tick low after reset", int'(tick), 0);
        // R6: first period uses the seed of index 0
        wait_tick(n);
        check("R6 first period", n, period_steps(9'h1AC));

        // R7 and R8: each rate index produces its own interval
        for (int i = 0; i < NVEC; i++) begin
            write_rate(VEC[i][12:9]);
            wait_tick(n);
            wait_tick(n);
            check($sformatf("R7 R8 rate %0d", i), n, period_steps(VEC[i][8:0]));
        end

        // R5: a mid-period rate change leaves the running period alone
        write_rate(4'd3);
        wait_tick(n);
        for (int k = 0; k < 5; k++) do_step(t);
        write_rate(4'd7);
        wait_tick(n);
        check("R5 running period unchanged", n + 5, period_steps(9'h153));
        wait_tick(n);
        check("R5 new rate at next reload", n, period_steps(9'h12F));

        // R9: index changes without strobe are ignored
        rate_idx = 4'd12;
        wait_tick(n);
        check("R9 no strobe period 1", n, period_steps(9'h12F));
        wait_tick(n);
        check("R9 no strobe period 2", n, period_steps(9'h12F));

        // R4: with the enable held low, nothing advances
        for (int k = 0; k < 10; k++) do_step(t);
        m = 0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (tick) m++;
        end
        check("R4 no tick while idle", m, 0);
        wait_tick(n);
        check("R4 count resumes", n + 10, period_steps(9'h12F));

        // R6: reset mid-period returns to index 0
        for (int k = 0; k < 7; k++) do_step(t);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        wait_tick(n);
        check("R6 reset restarts index 0", n, period_steps(9'h1AC));
        wait_tick(n);
        check("R6 index cleared by reset", n, period_steps(9'h1AC));

        done = 1'b1;
        summary();
    end
endmodule